// File: doc/BRIEF.md
# Display Controller Host Register File

This block is the host-facing register set of a display controller. The host reaches it through two 32-bit ports. A write to the index port selects a register. Reads and writes of the value port then act on that register. A third port is reserved for firmware use. It reads as zero and ignores writes. The ports sit at multiples of a parameterised I/O stride.

The block holds these registers:
- the negotiated interface ID
- the enable and configuration-complete flags
- the requested width, height and bits per pixel
- the guest identifier
- the cursor identity, position and visibility
- a bank of general scratch words above a high base index

Several read-only indices report the capability word, the size limits, the bytes per line derived from the mode, and the scratch count. The mode and cursor state leave the block as plain outputs. A write to the sync register raises a one-cycle kick toward a command processor. It also holds a busy flag until the processor reports completion.

Top module: `disp_host_regs`

## Requirements
- R1: The index port is at offset 0, the value port at offset IO_STRIDE (default 1) and the firmware port at 2×IO_STRIDE. Reading the index port returns the last index written. The firmware port reads 0 and ignores writes. Any other offset reads 0xFFFFFFFF and ignores writes.
- R2: The ID register (index 0) resets to 0x90000002. A write updates it only with 0x90000000, 0x90000001 or 0x90000002. Any other value leaves it unchanged.
- R3: The width register (index 2) resets to 640. A write is accepted only when the value is at most MAX_WIDTH (default 2368). Larger values are ignored.
- R4: The height register (index 3) resets to 480. A write is accepted only when the value is at most MAX_HEIGHT (default 1770). Larger values are ignored.
- R5: The bits-per-pixel register (index 7) resets to 32. It accepts only the values 8, 16, 24 and 32. The depth register (index 6) reads 24 when bits per pixel is 32, and reads bits per pixel otherwise.
- R6: Index 12 reads bits-per-pixel × width / 8 for the current mode.
- R7: Index 4 reads MAX_WIDTH, index 5 reads MAX_HEIGHT, index 17 reads CAPS (default 0x000000E3) and index 29 reads SCRATCH_WORDS. Writes to these indices change nothing.
- R8: The cursor ID (24), X (25) and Y (26) registers are 32-bit read/write. A write to index 27 affects the visibility flag as follows:
  - value 1 sets it;
  - value 0 clears it;
  - values 2 and 3 leave it unchanged.
  Index 27 reads the flag.
- R9: A write to index 21 drives sync_kick high for exactly the following cycle and sets busy. Busy reads at index 22 and on sync_busy. It clears on a cycle where sync_done is high and no new sync write occurs.
- R10: Scratch word k is at index 1792+k for k below SCRATCH_WORDS (default 16) and is read/write. Index 1792+SCRATCH_WORDS reads 0 and ignores writes.
- R11: Enable (index 1) and config-done (index 20) store 1 for any nonzero write and 0 for zero. The guest ID (index 23) is 32-bit read/write. The enable and config-done values appear on out_enable and out_config.
- R12: Any unimplemented index (for example 8, 30 and 1000) reads 0, and writes to it change no register.
- R13: After reset the following hold:
  - the index reads 0;
  - cursor state, guest ID, enable, config-done, busy and scratch are all 0;
  - the mode outputs show 640, 480 and 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one access |
| bus_rd | input | 1 | Read strobe (reads have no side effects) |
| bus_addr | input | ADDR_W | Port offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset and index |
| out_enable | output | 1 | Display enable |
| out_config | output | 1 | Configuration complete |
| out_width | output | DIM_W | Requested width |
| out_height | output | DIM_W | Requested height |
| out_bpp | output | 8 | Requested bits per pixel |
| cursor_x | output | 32 | Cursor X |
| cursor_y | output | 32 | Cursor Y |
| cursor_vis | output | 1 | Cursor visible |
| sync_kick | output | 1 | One-cycle command run request |
| sync_busy | output | 1 | Sync outstanding |
| sync_done | input | 1 | Command processor finished |

## Verification
The assertions assume the host never raises bus_wr and bus_rd together. They also assume sync_done arrives only as a response, which matters only for the busy-flag relation. The bench drives one access per cycle on the negative edge. It raises sync_done only while it tracks a sync as outstanding, apart from one directed case where done and a new sync write coincide. The random phase draws legal and illegal mode values from a fixed seed, so both the accept and the reject paths of the range checks run.

// File: rtl/disp_regs_pkg.sv
package disp_regs_pkg;
   localparam logic [31:0] ID_BASE   = 32'h9000_0000;
   localparam logic [31:0] IX_ID     = 32'd0;
   localparam logic [31:0] IX_ENABLE = 32'd1;
   localparam logic [31:0] IX_WIDTH  = 32'd2;
   localparam logic [31:0] IX_HEIGHT = 32'd3;
   localparam logic [31:0] IX_MAXW   = 32'd4;
   localparam logic [31:0] IX_MAXH   = 32'd5;
   localparam logic [31:0] IX_DEPTH  = 32'd6;
   localparam logic [31:0] IX_BPP    = 32'd7;
   localparam logic [31:0] IX_BPL    = 32'd12;
   localparam logic [31:0] IX_CAPS   = 32'd17;
   localparam logic [31:0] IX_CFG    = 32'd20;
   localparam logic [31:0] IX_SYNC   = 32'd21;
   localparam logic [31:0] IX_BUSY   = 32'd22;
   localparam logic [31:0] IX_GUEST  = 32'd23;
   localparam logic [31:0] IX_CUR_ID = 32'd24;
   localparam logic [31:0] IX_CUR_X  = 32'd25;
   localparam logic [31:0] IX_CUR_Y  = 32'd26;
   localparam logic [31:0] IX_CUR_ON = 32'd27;
   localparam logic [31:0] IX_SCRN   = 32'd29;
   localparam logic [31:0] IX_SCR0   = 32'd1792;

   function automatic logic id_legal(input logic [31:0] v);
      return (v == ID_BASE) || (v == (ID_BASE | 32'd1)) || (v == (ID_BASE | 32'd2));
   endfunction

   function automatic logic bpp_legal(input logic [31:0] v);
      return (v == 32'd8) || (v == 32'd16) || (v == 32'd24) || (v == 32'd32);
   endfunction
endpackage

// File: rtl/disp_port_dec.sv
module disp_port_dec #(
   parameter int ADDR_W    = 4,
   parameter int IO_STRIDE = 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              sel_idx,
   output logic              sel_val,
   output logic              sel_fw
);
   localparam int OFS_VAL = IO_STRIDE;
   localparam int OFS_FW  = 2 * IO_STRIDE;

   generate
      if (!(IO_STRIDE == 1 || IO_STRIDE == 4)) begin : g_bad_stride
         $error("disp_port_dec: IO_STRIDE must be 1 or 4");
      end
      if ((1 << ADDR_W) <= OFS_FW) begin : g_bad_addr
         $error("disp_port_dec: ADDR_W too small for the port offsets");
      end
   endgenerate

   assign sel_idx = (addr == ADDR_W'(0));
   assign sel_val = (addr == ADDR_W'(OFS_VAL));
   assign sel_fw  = (addr == ADDR_W'(OFS_FW));
endmodule

// File: rtl/disp_scratch_bank.sv
module disp_scratch_bank #(
   parameter int          WORDS = 16,
   parameter logic [31:0] BASE  = 32'd1792
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] index,
   input  logic [31:0] wdata,
   output logic        hit,
   output logic [31:0] rdata
);
   localparam int OFS_W = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam logic [31:0] TOP = BASE + 32'(WORDS);

   generate
      if (WORDS < 1 || WORDS > 1024) begin : g_bad_words
         $error("disp_scratch_bank: WORDS out of range");
      end
   endgenerate

   logic [31:0]      words [WORDS];
   logic [31:0]      rel;
   logic [OFS_W-1:0] ofs;

   assign hit = (index >= BASE) && (index < TOP);
   assign rel = index - BASE;
   assign ofs = rel[OFS_W-1:0];

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            words[k] <= '0;
         else if (wr_en && index == BASE + 32'(k))
            words[k] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (hit)
         rdata = words[ofs];
   end
endmodule

// File: rtl/disp_mode_regs.sv
module disp_mode_regs
   import disp_regs_pkg::*;
#(
   parameter int          DIM_W      = 16,
   parameter int          MAX_WIDTH  = 2368,
   parameter int          MAX_HEIGHT = 1770,
   parameter int          RST_WIDTH  = 640,
   parameter int          RST_HEIGHT = 480,
   parameter logic [31:0] CAPS       = 32'h0000_00E3,
   parameter int          SCR_WORDS  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [31:0]      index,
   input  logic [31:0]      wdata,
   input  logic             sync_done,
   output logic [31:0]      rdata,
   output logic             enable,
   output logic             config_done,
   output logic [DIM_W-1:0] width,
   output logic [DIM_W-1:0] height,
   output logic [7:0]       bpp,
   output logic [31:0]      cur_x,
   output logic [31:0]      cur_y,
   output logic             cur_vis,
   output logic             kick,
   output logic             busy
);
   generate
      if ((1 << DIM_W) <= MAX_WIDTH || (1 << DIM_W) <= MAX_HEIGHT) begin : g_bad_dim
         $error("disp_mode_regs: DIM_W cannot hold the limits");
      end
      if (RST_WIDTH > MAX_WIDTH || RST_HEIGHT > MAX_HEIGHT) begin : g_bad_rst
         $error("disp_mode_regs: reset mode exceeds limits");
      end
   endgenerate

   logic [31:0] id_q, guest_q, cur_id_q;
   logic [31:0] bpl;
   logic        wr_sync;

   assign wr_sync = wr_en && (index == IX_SYNC);
   assign bpl     = (32'(width) * 32'(bpp)) >> 3;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q        <= ID_BASE | 32'd2;
         enable      <= 1'b0;
         config_done <= 1'b0;
         width       <= DIM_W'(RST_WIDTH);
         height      <= DIM_W'(RST_HEIGHT);
         bpp         <= 8'd32;
         guest_q     <= '0;
         cur_id_q    <= '0;
         cur_x       <= '0;
         cur_y       <= '0;
         cur_vis     <= 1'b0;
         kick        <= 1'b0;
         busy        <= 1'b0;
      end else begin
         kick <= wr_sync;
         if (wr_sync)
            busy <= 1'b1;
         else if (sync_done)
            busy <= 1'b0;
         if (wr_en) begin
            unique case (index)
               IX_ID:     if (id_legal(wdata)) id_q <= wdata;
               IX_ENABLE: enable <= (wdata != '0);
               IX_WIDTH:  if (wdata <= 32'(MAX_WIDTH)) width <= wdata[DIM_W-1:0];
               IX_HEIGHT: if (wdata <= 32'(MAX_HEIGHT)) height <= wdata[DIM_W-1:0];
               IX_BPP:    if (bpp_legal(wdata)) bpp <= wdata[7:0];
               IX_CFG:    config_done <= (wdata != '0);
               IX_GUEST:  guest_q <= wdata;
               IX_CUR_ID: cur_id_q <= wdata;
               IX_CUR_X:  cur_x <= wdata;
               IX_CUR_Y:  cur_y <= wdata;
               IX_CUR_ON: begin
                  if (wdata == 32'd1)
                     cur_vis <= 1'b1;
                  else if (wdata == 32'd0)
                     cur_vis <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (index)
         IX_ID:     rdata = id_q;
         IX_ENABLE: rdata = 32'(enable);
         IX_WIDTH:  rdata = 32'(width);
         IX_HEIGHT: rdata = 32'(height);
         IX_MAXW:   rdata = 32'(MAX_WIDTH);
         IX_MAXH:   rdata = 32'(MAX_HEIGHT);
         IX_DEPTH:  rdata = (bpp == 8'd32) ? 32'd24 : 32'(bpp);
         IX_BPP:    rdata = 32'(bpp);
         IX_BPL:    rdata = bpl;
         IX_CAPS:   rdata = CAPS;
         IX_CFG:    rdata = 32'(config_done);
         IX_BUSY:   rdata = 32'(busy);
         IX_GUEST:  rdata = guest_q;
         IX_CUR_ID: rdata = cur_id_q;
         IX_CUR_X:  rdata = cur_x;
         IX_CUR_Y:  rdata = cur_y;
         IX_CUR_ON: rdata = 32'(cur_vis);
         IX_SCRN:   rdata = 32'(SCR_WORDS);
         default:   rdata = '0;
      endcase
   end

   // R2: the stored ID is always one of the three legal codes
   p_id_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      id_legal(id_q));
   // R3: width never exceeds its limit
   p_width_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(width) <= 32'(MAX_WIDTH));
   // R4: height never exceeds its limit
   p_height_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
      32'(height) <= 32'(MAX_HEIGHT));
   // R5: bits per pixel always one of the legal set
   p_bpp_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bpp_legal(32'(bpp)));
   // R8: codes 2 and 3 leave visibility alone
   p_cursor_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && index == IX_CUR_ON && wdata > 32'd1) |=> $stable(cur_vis));
   // R9: a kick is always accompanied by busy
   p_kick_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      kick |-> busy);
   // R9: a sync write kicks in the next cycle
   p_sync_kick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sync |=> kick);
endmodule

// File: rtl/disp_host_regs.sv
module disp_host_regs
   import disp_regs_pkg::*;
#(
   parameter int          ADDR_W        = 4,
   parameter int          IO_STRIDE     = 1,
   parameter int          DIM_W         = 16,
   parameter int          MAX_WIDTH     = 2368,
   parameter int          MAX_HEIGHT    = 1770,
   parameter int          SCRATCH_WORDS = 16,
   parameter logic [31:0] CAPS          = 32'h0000_00E3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              out_enable,
   output logic              out_config,
   output logic [DIM_W-1:0]  out_width,
   output logic [DIM_W-1:0]  out_height,
   output logic [7:0]        out_bpp,
   output logic [31:0]       cursor_x,
   output logic [31:0]       cursor_y,
   output logic              cursor_vis,
   output logic              sync_kick,
   output logic              sync_busy,
   input  logic              sync_done
);
   logic        sel_idx, sel_val, sel_fw;
   logic [31:0] index_q;
   logic        val_wr;
   logic [31:0] ctl_rdata, scr_rdata;
   logic        scr_hit;

   disp_port_dec #(.ADDR_W(ADDR_W), .IO_STRIDE(IO_STRIDE)) u_dec (
      .addr(bus_addr), .sel_idx(sel_idx), .sel_val(sel_val), .sel_fw(sel_fw)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         index_q <= '0;
      else if (bus_wr && sel_idx)
         index_q <= bus_wdata;
   end

   assign val_wr = bus_wr && sel_val;

   disp_mode_regs #(
      .DIM_W(DIM_W), .MAX_WIDTH(MAX_WIDTH), .MAX_HEIGHT(MAX_HEIGHT),
      .RST_WIDTH(640), .RST_HEIGHT(480), .CAPS(CAPS), .SCR_WORDS(SCRATCH_WORDS)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .wr_en(val_wr), .index(index_q),
      .wdata(bus_wdata), .sync_done(sync_done), .rdata(ctl_rdata),
      .enable(out_enable), .config_done(out_config), .width(out_width),
      .height(out_height), .bpp(out_bpp), .cur_x(cursor_x), .cur_y(cursor_y),
      .cur_vis(cursor_vis), .kick(sync_kick), .busy(sync_busy)
   );

   disp_scratch_bank #(.WORDS(SCRATCH_WORDS), .BASE(IX_SCR0)) u_scr (
      .clk(clk), .rst_n(rst_n), .wr_en(val_wr), .index(index_q),
      .wdata(bus_wdata), .hit(scr_hit), .rdata(scr_rdata)
   );

   always_comb begin
      if (sel_idx)
         bus_rdata = index_q;
      else if (sel_val)
         bus_rdata = scr_hit ? scr_rdata : ctl_rdata;
      else if (sel_fw)
         bus_rdata = '0;
      else
         bus_rdata = '1;
   end

   // R1: the index only moves on an index-port write
   p_index_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && sel_idx) |=> $stable(index_q));
   // R1: host never reads and writes in one access
   p_one_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));
endmodule

// File: tb/disp_host_regs_bench.sv
module disp_host_regs_bench;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [3:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0;
   logic [31:0] bus_rdata;
   logic        out_enable, out_config, cursor_vis, sync_kick, sync_busy;
   logic        sync_done = 0;
   logic [15:0] out_width, out_height;
   logic [7:0]  out_bpp;
   logic [31:0] cursor_x, cursor_y;

   int errors = 0, checks = 0;
   bit done_flag = 0;

   always #5 clk = ~clk;

   disp_host_regs u_disp_host_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .out_enable(out_enable), .out_config(out_config), .out_width(out_width),
      .out_height(out_height), .out_bpp(out_bpp), .cursor_x(cursor_x),
      .cursor_y(cursor_y), .cursor_vis(cursor_vis), .sync_kick(sync_kick),
      .sync_busy(sync_busy), .sync_done(sync_done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_port(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd_port(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1;
      #1 d = bus_rdata;
      bus_rd = 0;
   endtask

   task automatic wr_reg(input logic [31:0] ix, input logic [31:0] d);
      wr_port(4'd0, ix);
      wr_port(4'd1, d);
   endtask

   task automatic rd_reg(input logic [31:0] ix, output logic [31:0] d);
      wr_port(4'd0, ix);
      rd_port(4'd1, d);
   endtask

   function automatic logic [31:0] exp_depth(input logic [31:0] b);
      return (b == 32) ? 32'd24 : b;
   endfunction

   function automatic logic [31:0] exp_bpl(input logic [31:0] b, input logic [31:0] w);
      return (b * w) / 8;
   endfunction

   initial begin
      #2_000_000;
      if (!done_flag) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] mw, mh, mb;
      logic [31:0] scr [16];
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R13 reset state
      rd_port(4'd0, d); chk("R13 index", d, 0);
      chk("R13 width", 32'(out_width), 640);
      chk("R13 height", 32'(out_height), 480);
      chk("R13 bpp", 32'(out_bpp), 32);
      chk("R13 flags", {27'd0, out_enable, out_config, cursor_vis, sync_kick, sync_busy}, 0);
      chk("R13 cursor", cursor_x | cursor_y, 0);
      rd_reg(32'd23, d); chk("R13 guest", d, 0);
      rd_reg(32'd1792, d); chk("R13 scratch", d, 0);
      rd_reg(32'd0, d); chk("R2 id reset", d, 32'h9000_0002);

      // R1 ports
      wr_port(4'd0, 32'd5); rd_port(4'd0, d); chk("R1 index readback", d, 5);
      rd_port(4'd2, d); chk("R1 fw read", d, 0);
      rd_port(4'd3, d); chk("R1 unknown read", d, 32'hFFFF_FFFF);
      wr_port(4'd3, 32'd99); rd_port(4'd0, d); chk("R1 unknown write ignored", d, 5);
      wr_port(4'd2, 32'd77); rd_port(4'd0, d); chk("R1 fw write ignored", d, 5);

      // R2 ID negotiation
      wr_reg(32'd0, 32'h9000_0001); rd_port(4'd1, d); chk("R2 id accept", d, 32'h9000_0001);
      wr_reg(32'd0, 32'h9000_0003); rd_port(4'd1, d); chk("R2 id reject", d, 32'h9000_0001);
      wr_reg(32'd0, 32'h9000_0000); rd_port(4'd1, d); chk("R2 id v0", d, 32'h9000_0000);

      // R3/R4 boundaries
      wr_reg(32'd2, 32'd2368); chk("R3 width at max", 32'(out_width), 2368);
      wr_reg(32'd2, 32'd2369); chk("R3 width over", 32'(out_width), 2368);
      wr_reg(32'd3, 32'd1770); chk("R4 height at max", 32'(out_height), 1770);
      wr_reg(32'd3, 32'd1771); chk("R4 height over", 32'(out_height), 1770);

      // R5 depth
      rd_reg(32'd6, d); chk("R5 depth 32->24", d, 24);
      wr_reg(32'd7, 32'd12); chk("R5 bpp reject", 32'(out_bpp), 32);
      wr_reg(32'd7, 32'd16); rd_reg(32'd6, d); chk("R5 depth 16", d, 16);

      // R7 fixed values
      rd_reg(32'd4, d); chk("R7 maxw", d, 2368);
      rd_reg(32'd5, d); chk("R7 maxh", d, 1770);
      rd_reg(32'd17, d); chk("R7 caps", d, 32'hE3);
      wr_reg(32'd29, 32'd3); rd_port(4'd1, d); chk("R7 scratch count", d, 16);

      // R8 cursor
      wr_reg(32'd24, 32'hABCD); rd_port(4'd1, d); chk("R8 cursor id", d, 32'hABCD);
      wr_reg(32'd25, 32'd111); chk("R8 cursor x", cursor_x, 111);
      wr_reg(32'd26, 32'd222); chk("R8 cursor y", cursor_y, 222);
      wr_reg(32'd27, 32'd1); chk("R8 show", 32'(cursor_vis), 1);
      wr_port(4'd1, 32'd2); chk("R8 code2 keeps", 32'(cursor_vis), 1);
      wr_port(4'd1, 32'd0); chk("R8 hide", 32'(cursor_vis), 0);
      wr_port(4'd1, 32'd3); chk("R8 code3 keeps", 32'(cursor_vis), 0);
      rd_port(4'd1, d); chk("R8 on readback", d, 0);

      // R11 flags and guest
      wr_reg(32'd1, 32'd7); chk("R11 enable", 32'(out_enable), 1);
      wr_reg(32'd20, 32'd5); chk("R11 config", 32'(out_config), 1);
      rd_port(4'd1, d); chk("R11 config read", d, 1);
      wr_reg(32'd1, 32'd0); chk("R11 enable clear", 32'(out_enable), 0);
      wr_reg(32'd23, 32'h5001_0006); rd_port(4'd1, d); chk("R11 guest", d, 32'h5001_0006);

      // R9 sync
      wr_reg(32'd21, 32'd1);
      chk("R9 kick", 32'(sync_kick), 1);
      chk("R9 busy set", 32'(sync_busy), 1);
      @(negedge clk);
      chk("R9 kick one cycle", 32'(sync_kick), 0);
      rd_reg(32'd22, d); chk("R9 busy read", d, 1);
      sync_done = 1; wr_reg(32'd21, 32'd0); sync_done = 0;
      chk("R9 write beats done", 32'(sync_busy), 1);
      sync_done = 1; @(negedge clk); sync_done = 0;
      chk("R9 busy clear", 32'(sync_busy), 0);
      rd_reg(32'd22, d); chk("R9 busy read clear", d, 0);

      // R10 scratch bounds
      wr_reg(32'd1807, 32'hDEAD_BEEF); rd_port(4'd1, d); chk("R10 last word", d, 32'hDEAD_BEEF);
      wr_reg(32'd1808, 32'h1234); rd_port(4'd1, d); chk("R10 beyond", d, 0);
      rd_reg(32'd1807, d); chk("R10 beyond no alias", d, 32'hDEAD_BEEF);

      // R12 unimplemented
      foreach (scr[k]) scr[k] = 0;
      scr[15] = 32'hDEAD_BEEF;
      wr_reg(32'd8, 32'h55); rd_port(4'd1, d); chk("R12 idx8", d, 0);
      wr_reg(32'd30, 32'h55); rd_port(4'd1, d); chk("R12 idx30", d, 0);
      wr_reg(32'd1000, 32'h55); rd_port(4'd1, d); chk("R12 idx1000", d, 0);
      chk("R12 mode untouched", 32'(out_width), 2368);

      // random mode and scratch traffic (R3 R4 R5 R6 R10)
      mw = 2368; mh = 1770; mb = 16;
      for (int i = 0; i < 150; i++) begin
         logic [31:0] v;
         int sel;
         sel = int'($urandom % 4);
         if (sel == 0) begin
            v = $urandom % 3000;
            wr_reg(32'd2, v);
            if (v <= 2368) mw = v;
         end else if (sel == 1) begin
            v = $urandom % 2200;
            wr_reg(32'd3, v);
            if (v <= 1770) mh = v;
         end else if (sel == 2) begin
            v = 32'(($urandom % 5) * 8);
            if (($urandom % 4) == 0) v = v + 1;
            wr_reg(32'd7, v);
            if (v == 8 || v == 16 || v == 24 || v == 32) mb = v;
         end else begin
            int k;
            k = int'($urandom % 16);
            v = $urandom;
            wr_reg(32'd1792 + 32'(k), v);
            scr[k] = v;
         end
         rd_reg(32'd12, d); chk("R6 bytes per line", d, exp_bpl(mb, mw));
         rd_reg(32'd6, d); chk("R5 depth random", d, exp_depth(mb));
         chk("R3 width random", 32'(out_width), mw);
         chk("R4 height random", 32'(out_height), mh);
      end
      for (int k = 0; k < 16; k++) begin
         rd_reg(32'd1792 + 32'(k), d); chk("R10 scratch random", d, scr[k]);
      end

      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule